// File: doc/BRIEF.md
# Interrupt Gate and Software Reset Unit

This block sits beside the control register bank of a bus-attached accelerator. It has three interrupt registers and one reset register, all on a simple single-word register bus. The first interrupt register is a master enable. The second shows the level of the core's request. The third is an enable for that one source. The block combines these three into a single registered interrupt line for the processor.

The same block decodes a write-only reset register. A write of the key value 0x0000000A there starts a reset pulse of fixed length. Every other part of the peripheral takes this pulse as its reset. While the pulse lasts, the block also clears its own enable registers. Any other value written to that register does nothing. Software finds the cause of an interrupt by reading the flags in the control register block. The status bit here only follows the request level, so it drops when software clears those flags.

Top module: `irqg_top`

## Requirements
- R1: After the hardware reset, `irq_o` and `periph_rst_o` are 0, and the master enable and source enable both read back as 0.
- R2: The master enable register sits at byte offset 0x21C. Only bit 31 is stored and can be read back. Bits 30..0 read 0.
- R3: The source enable register sits at byte offset 0x228. Only bit 0 is stored and can be read back. Bits 31..1 read 0.
- R4: The status register sits at byte offset 0x220 and is read-only. Bit 0 shows `core_irq_req` as sampled in the read cycle, and the other bits read 0. A write to this offset changes nothing that can be read.
- R5: `irq_o` in the cycle after a clock edge equals master enable AND source enable AND `core_irq_req`, all as they stood before that edge. A write to an enable therefore shows on `irq_o` one cycle after the write edge.
- R6: A write of exactly 0x0000000A to byte offset 0x100 raises `periph_rst_o` from the cycle after the write edge, and keeps it high for exactly PULSE_LEN cycles (default 16).
- R7: A write of any other value to offset 0x100 leaves `periph_rst_o` low and both enables unchanged.
- R8: A key write clears both enables at its own edge. They stay cleared, and writes to them are dropped, while `periph_rst_o` is high. From the second pulse cycle on, `irq_o` is 0.
- R9: A read of offset 0x100, or of any offset not named above, returns 0. A write to an offset not named above changes no register.
- R10: `bus_rdata` holds the selected word in the cycle after a read strobe, and 0 after a cycle with no read.
- R11: A key write made while the pulse is running restarts the count, so `periph_rst_o` stays high for PULSE_LEN cycles after that later write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| bus_wr | input | 1 | Write strobe, one cycle per word |
| bus_rd | input | 1 | Read strobe, one cycle per word |
| bus_addr | input | ADDR_W | Byte offset in the block's space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_irq_req | input | 1 | Level interrupt request from the control register block |
| irq_o | output | 1 | Registered interrupt line to the processor |
| periph_rst_o | output | 1 | Active-high reset pulse for the whole peripheral |

## Verification
Two things can happen in the same cycle: a soft reset and a live interrupt. The key write can arrive while both enables are set and the request is high, and a later enable write can land inside the pulse. The bench sets up an asserted `irq_o` and then issues the key in the very next write, still holding the request. It expects the line to drop on the second pulse cycle and the pulse to last exactly its length. It then writes the master enable during the pulse and reads it back as 0 once the pulse is over. A second key write halfway through a pulse checks that the count restarts.

// File: rtl/irqg_pkg.sv
package irqg_pkg;

  localparam int unsigned REG_W = 32;

  // register byte offsets (placement is software-visible)
  localparam logic [31:0] OFS_SRST = 32'h0000_0100;
  localparam logic [31:0] OFS_GIE  = 32'h0000_021C;
  localparam logic [31:0] OFS_STAT = 32'h0000_0220;
  localparam logic [31:0] OFS_IEN  = 32'h0000_0228;

  localparam logic [REG_W-1:0] SRST_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_SRST,
    RS_GIE,
    RS_STAT,
    RS_IEN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_SRST: s = RS_SRST;
      OFS_GIE:  s = RS_GIE;
      OFS_STAT: s = RS_STAT;
      OFS_IEN:  s = RS_IEN;
      default:  s = RS_NONE;
    endcase
    return s;
  endfunction

  // placement of each defined bit inside its word
  function automatic logic [REG_W-1:0] read_word(input reg_sel_e sel, input logic gie,
                                                 input logic ien, input logic stat);
    logic [REG_W-1:0] w;
    w = '0;
    case (sel)
      RS_GIE:  w[REG_W-1] = gie;
      RS_IEN:  w[0]       = ien;
      RS_STAT: w[0]       = stat;
      default: w          = '0;
    endcase
    return w;
  endfunction

  function automatic logic gate_irq(input logic gie, input logic ien, input logic req);
    return gie & ien & req;
  endfunction

endpackage

// File: rtl/irqg_decode.sv
module irqg_decode
  import irqg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output reg_sel_e          sel,
  output logic              wr_gie,
  output logic              wr_ien,
  output logic              key_hit,
  output logic              rd_en
);

  logic [31:0] ofs_ext;
  logic        wr_srst;

  assign ofs_ext = 32'(bus_addr);
  assign sel     = decode_ofs(ofs_ext);
  assign wr_gie  = bus_wr && (sel == RS_GIE);
  assign wr_ien  = bus_wr && (sel == RS_IEN);
  assign wr_srst = bus_wr && (sel == RS_SRST);
  assign key_hit = wr_srst && (bus_wdata == SRST_KEY);
  assign rd_en   = bus_rd;

  // at most one register strobe per cycle
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_gie, wr_ien, key_hit}));

endmodule

// File: rtl/irqg_srst_gen.sv
module irqg_srst_gen #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  output logic srst_active
);

  localparam int unsigned CNT_W = $clog2(PULSE_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] c, input logic load);
    if (load)            return CNT_LOAD;
    else if (c != '0)    return c - 1'b1;
    else                 return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, key_hit);
  end

  assign srst_active = (cnt_q != '0);

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> srst_active);
  p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LOAD);
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> (cnt_q == CNT_LOAD));

endmodule

// File: rtl/irqg_enables.sv
module irqg_enables (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_gie,
  input  logic wr_ien,
  input  logic gie_d,
  input  logic ien_d,
  output logic gie_q,
  output logic ien_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      gie_q <= 1'b0;
      ien_q <= 1'b0;
    end else begin
      if (wr_gie) gie_q <= gie_d;
      if (wr_ien) ien_q <= ien_d;
    end
  end

  p_hold_gie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_gie && !clr) |=> $stable(gie_q));
  p_hold_ien_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ien && !clr) |=> $stable(ien_q));

endmodule

// File: rtl/irqg_irq_out.sv
module irqg_irq_out
  import irqg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic gie,
  input  logic ien,
  input  logic req,
  output logic irq_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= gate_irq(gie, ien, req);
  end

  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && ien && req) |=> irq_o);
  p_irq_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie || !ien || !req) |=> !irq_o);

endmodule

// File: rtl/irqg_top.sv
module irqg_top
  import irqg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              core_irq_req,
  output logic              irq_o,
  output logic              periph_rst_o
);

  reg_sel_e   sel;
  logic       wr_gie, wr_ien, key_hit, rd_en;
  logic       srst_active, clr_en;
  logic       gie_q, ien_q;
  logic [31:0] rdata_q;

  irqg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sel(sel),
    .wr_gie(wr_gie), .wr_ien(wr_ien), .key_hit(key_hit), .rd_en(rd_en)
  );

  irqg_srst_gen #(.PULSE_LEN(PULSE_LEN)) u_srst (
    .clk(clk), .rst_n(rst_n), .key_hit(key_hit), .srst_active(srst_active)
  );

  // key edge itself clears the enables, then the running pulse holds them
  assign clr_en = key_hit | srst_active;

  irqg_enables u_en (
    .clk(clk), .rst_n(rst_n), .clr(clr_en),
    .wr_gie(wr_gie), .wr_ien(wr_ien),
    .gie_d(bus_wdata[31]), .ien_d(bus_wdata[0]),
    .gie_q(gie_q), .ien_q(ien_q)
  );

  irqg_irq_out u_irq (
    .clk(clk), .rst_n(rst_n), .gie(gie_q), .ien(ien_q),
    .req(core_irq_req), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= read_word(sel, gie_q, ien_q, core_irq_req);
    else            rdata_q <= '0;
  end

  assign bus_rdata    = rdata_q;
  assign periph_rst_o = srst_active;

  p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> (!gie_q && !ien_q));
  p_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |=> !irq_o);
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 32'h0));
  p_nonkey_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (32'(bus_addr) == OFS_SRST) && (bus_wdata != SRST_KEY) && !periph_rst_o)
      |=> !periph_rst_o);

endmodule

// File: tb/irqg_top_tb_top.sv
`timescale 1ns/1ps
module irqg_top_tb_top;

  localparam int unsigned AW = 12;
  localparam int unsigned PL = 16;
  localparam logic [AW-1:0] A_RST  = 12'h100;
  localparam logic [AW-1:0] A_GIE  = 12'h21C;
  localparam logic [AW-1:0] A_STAT = 12'h220;
  localparam logic [AW-1:0] A_IEN  = 12'h228;
  localparam logic [31:0]   KEY    = 32'd10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic core_irq_req = 1'b0;
  logic irq_o, periph_rst_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irqg_top #(.ADDR_W(AW), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_irq_req(core_irq_req), .irq_o(irq_o), .periph_rst_o(periph_rst_o)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected read word, restated from the register map
  function automatic logic [31:0] model_rd(input logic [AW-1:0] a, input logic g,
                                           input logic e, input logic r);
    if (a == A_GIE)  return {g, 31'd0};
    if (a == A_IEN)  return {31'd0, e};
    if (a == A_STAT) return {31'd0, r};
    return 32'd0;
  endfunction

  task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int count_pulse_dummy();
    return 0;
  endfunction

  logic [31:0] rv;
  int          plen;

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(irq_o == 1'b0, "R1 irq", {31'd0, irq_o}, 32'd0);
    check(periph_rst_o == 1'b0, "R1 rst", {31'd0, periph_rst_o}, 32'd0);
    bus_read(A_GIE, rv); check(rv == 32'd0, "R1 gie", rv, 32'd0);
    bus_read(A_IEN, rv); check(rv == 32'd0, "R1 ien", rv, 32'd0);

    // R2 / R3 field placement
    bus_write(A_GIE, 32'hFFFF_FFFF);
    bus_read(A_GIE, rv); check(rv == 32'h8000_0000, "R2", rv, 32'h8000_0000);
    bus_write(A_IEN, 32'hFFFF_FFFF);
    bus_read(A_IEN, rv); check(rv == 32'h0000_0001, "R3", rv, 32'h1);

    // R4 status mirrors request; write ignored
    core_irq_req = 1'b1;
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, rv); check(rv == 32'h1, "R4 high", rv, 32'h1);
    core_irq_req = 1'b0;
    bus_read(A_STAT, rv); check(rv == 32'h0, "R4 low", rv, 32'h0);

    // R5 gating, one cycle latency
    core_irq_req = 1'b1;
    @(negedge clk);
    check(irq_o == 1'b1, "R5 on", {31'd0, irq_o}, 32'd1);
    bus_write(A_GIE, 32'h0);
    check(irq_o == 1'b1, "R5 latency", {31'd0, irq_o}, 32'd1);
    @(negedge clk);
    check(irq_o == 1'b0, "R5 off", {31'd0, irq_o}, 32'd0);
    bus_write(A_GIE, 32'h8000_0000);
    @(negedge clk);
    check(irq_o == 1'b1, "R5 back", {31'd0, irq_o}, 32'd1);

    // R7 wrong key: no pulse, enables kept
    bus_write(A_RST, 32'h0000_000B);
    check(periph_rst_o == 1'b0, "R7 pulse", {31'd0, periph_rst_o}, 32'd0);
    bus_read(A_GIE, rv); check(rv == 32'h8000_0000, "R7 gie", rv, 32'h8000_0000);

    // R9 undefined offsets / reset reg read
    bus_write(12'h224, 32'hFFFF_FFFF);
    bus_read(12'h224, rv); check(rv == 32'h0, "R9 undef", rv, 32'h0);
    bus_read(A_RST, rv);   check(rv == 32'h0, "R9 rstreg", rv, 32'h0);
    bus_read(A_IEN, rv);   check(rv == 32'h1, "R9 ien kept", rv, 32'h1);

    // R6 / R8 key write while irq is asserted and request held
    check(irq_o == 1'b1, "R8 pre", {31'd0, irq_o}, 32'd1);
    bus_write(A_RST, KEY);
    check(periph_rst_o == 1'b1, "R6 start", {31'd0, periph_rst_o}, 32'd1);
    plen = 0;
    // enable write inside the pulse must be dropped
    bus_write(A_GIE, 32'h8000_0000);
    plen = 2;
    check(irq_o == 1'b0, "R8 irq", {31'd0, irq_o}, 32'd0);
    while (periph_rst_o && plen < 40) begin
      plen++;
      @(negedge clk);
    end
    check(plen == PL, "R6 length", plen, PL);
    bus_read(A_GIE, rv); check(rv == 32'h0, "R8 gie", rv, 32'h0);
    bus_read(A_IEN, rv); check(rv == 32'h0, "R8 ien", rv, 32'h0);

    // R11 restart
    bus_write(A_RST, KEY);
    repeat (5) @(negedge clk);
    bus_write(A_RST, KEY);
    plen = 0;
    while (periph_rst_o && plen < 40) begin
      plen++;
      @(negedge clk);
    end
    check(plen == PL, "R11 restart", plen, PL);
    core_irq_req = 1'b0;

    // random section: R2 R3 R4 R5 R9 R10 with a cycle model
    begin
      logic g_m, e_m, exp_irq;
      logic [31:0] exp_rd;
      g_m = 1'b0; e_m = 1'b0; exp_irq = 1'b0; exp_rd = 32'h0;
      @(negedge clk);
      for (int i = 0; i < 400; i++) begin
        int op, ai;
        logic [AW-1:0] a;
        logic [31:0] d;
        logic r;
        check(irq_o == exp_irq, "R5 rand", {31'd0, irq_o}, {31'd0, exp_irq});
        check(bus_rdata == exp_rd, "R10 rand", bus_rdata, exp_rd);
        op = $urandom_range(0, 2);
        ai = $urandom_range(0, 5);
        case (ai)
          0: a = A_GIE;
          1: a = A_IEN;
          2: a = A_STAT;
          3: a = A_RST;
          4: a = 12'h004;
          default: a = 12'h22C;
        endcase
        d = $urandom;
        if (d == KEY) d = d ^ 32'h1;
        r = 1'($urandom_range(0, 1));
        bus_wr = (op == 1);
        bus_rd = (op == 2);
        bus_addr = a;
        bus_wdata = d;
        core_irq_req = r;
        exp_irq = g_m & e_m & r;
        exp_rd = (op == 2) ? model_rd(a, g_m, e_m, r) : 32'h0;
        if (op == 1 && a == A_GIE) g_m = d[31];
        if (op == 1 && a == A_IEN) e_m = d[0];
        @(negedge clk);
        if (periph_rst_o) check(1'b0, "R7 rand", 32'd1, 32'd0);
      end
      bus_wr = 1'b0; bus_rd = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule